// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory

This block keeps the sharer record for a small bank of directory entries. Each entry holds a few node pointers instead of one presence bit per node. Every pointer slot has its own valid bit. The coherence controller sends one command per cycle: add a sharer, remove a sharer, clear the entry, or enumerate the entry's invalidation targets.

Enumeration streams one target node per cycle, so the controller can send point-to-point invalidations. When an entry has taken more distinct sharers than it has slots, it enters a sticky overflow mode. From then on, enumeration gives a single broadcast indication that names the requester as the one node to exclude. The requester is never listed as its own invalidation target.

Message transport, acknowledgement counting and ownership tracking live outside this block.

Top module: `lpdir_sharer_dir`

## Requirements
- R1: After reset, `cmd_ready` is 1, `out_valid` is 0, and every entry is empty: enumerating any entry gives exactly one beat with kind NONE (`out_kind` = 2'b00) and `out_last` = 1.
- R2: An add of a node not yet recorded, on an entry that is not in overflow and has a free slot, writes the node into the lowest-numbered free slot. Enumeration lists node beats (`out_kind` = 2'b01) in ascending slot order.
- R3: An add of a node that is already recorded leaves the entry unchanged. This includes an entry whose slots are all full, which stays out of overflow.
- R4: An add of a new node to an entry whose SLOTS slots are all valid sets overflow. Enumerating an overflowed entry gives one beat of kind ALL (`out_kind` = 2'b10), with `out_node` equal to the requester and `out_last` = 1. Exactly SLOTS sharers do not overflow.
- R5: Once set, overflow stays set through any add or remove until a clear of that entry.
- R6: Removing a recorded node frees its slot, and a later add reuses the lowest free slot. Removing a node that is not recorded changes nothing.
- R7: A clear empties all slots of the entry and resets its overflow flag.
- R8: The enumerate command's `cmd_node` is the requester. A slot holding the requester is skipped. If no other valid slot remains, the single beat has kind NONE.
- R9: The first enumeration beat appears in the cycle after the command is accepted, and the beats then follow on consecutive cycles. `out_last` is 1 only on the final beat. `cmd_ready` is 0 during the beats and 1 again in the cycle after the last one. Command encoding on `cmd_op`: 00 add, 01 remove, 10 clear, 11 enumerate.
- R10: A command affects only the entry selected by `cmd_entry`. Under any mix of commands, every true sharer other than the requester is covered by the enumerated list or by the broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 add, 01 remove, 10 clear, 11 enumerate |
| cmd_entry | input | log2(ENTRIES) | Entry selected by the command |
| cmd_node | input | log2(NODES) | Node to add or remove, or requester for enumerate |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| out_valid | output | 1 | Enumeration beat present |
| out_kind | output | 2 | 00 none, 01 node, 10 broadcast |
| out_node | output | log2(NODES) | Target node, or the excluded requester on broadcast |
| out_last | output | 1 | Final beat of the enumeration |

## Verification
Internal state becomes visible only through enumeration. A wrong slot update therefore appears at the next enumerate command, within SLOTS+1 cycles, as an extra, missing or reordered node beat. A lost overflow flag turns a broadcast into a partial list that misses true sharers, and the full bit-vector model in the bench exposes that as an uncovered sharer. Disturbing a neighbouring entry shows up when that neighbour is enumerated later.

// File: rtl/lpdir_pkg.sv
package lpdir_pkg;

    typedef enum logic [1:0] {
        OP_ADD    = 2'b00,
        OP_REMOVE = 2'b01,
        OP_CLEAR  = 2'b10,
        OP_ENUM   = 2'b11
    } dir_op_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'b00,
        TGT_NODE = 2'b01,
        TGT_ALL  = 2'b10
    } tgt_kind_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lpdir_slot_match.sv
module lpdir_slot_match #(
    parameter int SLOTS = 5,
    parameter int PTR_W = 6
) (
    input  logic [SLOTS-1:0]            vld,
    input  logic [SLOTS-1:0][PTR_W-1:0] ptr,
    input  logic [PTR_W-1:0]            node,
    output logic [SLOTS-1:0]            hit_vec,
    output logic                        hit,
    output logic [SLOTS-1:0]            free_1h,
    output logic                        full
);
    localparam logic [SLOTS-1:0] ONE = SLOTS'(1);

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (ptr[g] == node);
    end

    // lowest clear valid bit, isolated as a one-hot vector
    assign free_1h = ~vld & (vld + ONE);
    assign full    = &vld;
    assign hit     = |hit_vec;

endmodule

// File: rtl/lpdir_entry_bank.sv
module lpdir_entry_bank
    import lpdir_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int SLOTS   = 5,
    parameter int PTR_W   = 6,
    parameter int IDX_W   = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        upd_valid,
    input  dir_op_e                     upd_op,
    input  logic [IDX_W-1:0]            sel_idx,
    input  logic [PTR_W-1:0]            upd_node,
    output logic                        sel_ovf,
    output logic [SLOTS-1:0]            sel_vld,
    output logic [SLOTS-1:0][PTR_W-1:0] sel_ptr
);
    logic                        ovf_q [ENTRIES];
    logic [SLOTS-1:0]            vld_q [ENTRIES];
    logic [SLOTS-1:0][PTR_W-1:0] ptr_q [ENTRIES];

    logic [SLOTS-1:0] hit_vec;
    logic [SLOTS-1:0] free_1h;
    logic             hit;
    logic             full;

    assign sel_ovf = ovf_q[sel_idx];
    assign sel_vld = vld_q[sel_idx];
    assign sel_ptr = ptr_q[sel_idx];

    lpdir_slot_match #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_match (
        .vld     (sel_vld),
        .ptr     (sel_ptr),
        .node    (upd_node),
        .hit_vec (hit_vec),
        .hit     (hit),
        .free_1h (free_1h),
        .full    (full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) begin
                ovf_q[e] <= 1'b0;
                vld_q[e] <= '0;
                ptr_q[e] <= '0;
            end
        end else if (upd_valid) begin
            unique case (upd_op)
                OP_ADD: begin
                    if (!sel_ovf && !hit) begin
                        if (full) begin
                            ovf_q[sel_idx] <= 1'b1;
                        end else begin
                            for (int s = 0; s < SLOTS; s++) begin
                                if (free_1h[s]) begin
                                    vld_q[sel_idx][s] <= 1'b1;
                                    ptr_q[sel_idx][s] <= upd_node;
                                end
                            end
                        end
                    end
                end
                OP_REMOVE: vld_q[sel_idx] <= sel_vld & ~hit_vec;
                OP_CLEAR: begin
                    ovf_q[sel_idx] <= 1'b0;
                    vld_q[sel_idx] <= '0;
                end
                default: ;
            endcase
        end
    end

    // R3: a duplicate add leaves the slot valid bits as they were
    a_r3_dup_add_stable: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_op == OP_ADD && hit) |=> vld_q[$past(sel_idx)] == $past(sel_vld));

    // R7: clear empties the entry and drops overflow
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_op == OP_CLEAR) |=> (vld_q[$past(sel_idx)] == '0 && !ovf_q[$past(sel_idx)]));

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry_chk
        // R5: overflow survives everything except a clear of its own entry
        a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
            (ovf_q[e] && !(upd_valid && upd_op == OP_CLEAR && sel_idx == IDX_W'(e))) |=> ovf_q[e]);
        // R10: commands on other entries leave this one alone
        a_r10_entry_isolated: assert property (@(posedge clk) disable iff (rst)
            (upd_valid && sel_idx != IDX_W'(e)) |=> (vld_q[e] == $past(vld_q[e]) && ovf_q[e] == $past(ovf_q[e])));
        for (genvar i = 0; i < SLOTS; i++) begin : g_i
            for (genvar j = i + 1; j < SLOTS; j++) begin : g_j
                // R3: a node never occupies two valid slots
                a_r3_unique_ptrs: assert property (@(posedge clk) disable iff (rst)
                    (vld_q[e][i] && vld_q[e][j]) |-> ptr_q[e][i] != ptr_q[e][j]);
            end
        end
    end

endmodule

// File: rtl/lpdir_enum.sv
module lpdir_enum
    import lpdir_pkg::*;
#(
    parameter int SLOTS = 5,
    parameter int PTR_W = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [PTR_W-1:0]            req,
    input  logic                        src_ovf,
    input  logic [SLOTS-1:0]            src_vld,
    input  logic [SLOTS-1:0][PTR_W-1:0] src_ptr,
    output logic                        busy,
    output logic                        out_valid,
    output tgt_kind_e                   out_kind,
    output logic [PTR_W-1:0]            out_node,
    output logic                        out_last
);
    localparam logic [SLOTS-1:0] ONE = SLOTS'(1);

    logic                        busy_q;
    tgt_kind_e                   mode_q;
    logic [SLOTS-1:0]            pend_q;
    logic [SLOTS-1:0][PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0]            req_q;

    logic [SLOTS-1:0] keep;
    logic [SLOTS-1:0] sel_1h;
    logic [SLOTS-1:0] rest;
    logic [PTR_W-1:0] pick;

    for (genvar g = 0; g < SLOTS; g++) begin : g_keep
        assign keep[g] = src_vld[g] && (src_ptr[g] != req);
    end

    assign sel_1h = pend_q & (~pend_q + ONE);
    assign rest   = pend_q & ~sel_1h;

    always_comb begin
        pick = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (sel_1h[s]) pick = pick | ptr_q[s];
        end
    end

    always_comb begin
        out_valid = busy_q;
        out_kind  = busy_q ? mode_q : TGT_NONE;
        out_last  = busy_q && ((mode_q != TGT_NODE) || (rest == '0));
        out_node  = '0;
        if (busy_q) begin
            if (mode_q == TGT_ALL)       out_node = req_q;
            else if (mode_q == TGT_NODE) out_node = pick;
        end
    end

    assign busy = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            mode_q <= TGT_NONE;
            pend_q <= '0;
            ptr_q  <= '0;
            req_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            ptr_q  <= src_ptr;
            req_q  <= req;
            if (src_ovf) begin
                mode_q <= TGT_ALL;
                pend_q <= '0;
            end else if (keep == '0) begin
                mode_q <= TGT_NONE;
                pend_q <= '0;
            end else begin
                mode_q <= TGT_NODE;
                pend_q <= keep;
            end
        end else if (busy_q) begin
            pend_q <= rest;
            if (out_last) busy_q <= 1'b0;
        end
    end

    // R9: beats come back to back until the last one, then stop
    a_r9_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);
    a_r9_stop_after_last: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |=> !out_valid);
    // R4: a broadcast is one beat naming the requester
    a_r4_bcast_single: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == TGT_ALL) |-> (out_last && out_node == req_q));
    // R8: the requester is never a listed target
    a_r8_skip_requester: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == TGT_NODE) |-> out_node != req_q);

endmodule

// File: rtl/lpdir_sharer_dir.sv
module lpdir_sharer_dir
    import lpdir_pkg::*;
#(
    parameter int NODES   = 64,
    parameter int SLOTS   = 5,
    parameter int ENTRIES = 8,
    localparam int PTR_W  = idx_width(NODES),
    localparam int IDX_W  = idx_width(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_entry,
    input  logic [PTR_W-1:0] cmd_node,
    output logic             cmd_ready,
    output logic             out_valid,
    output logic [1:0]       out_kind,
    output logic [PTR_W-1:0] out_node,
    output logic             out_last
);
    dir_op_e                     op;
    logic                        fire;
    logic                        busy;
    logic                        sel_ovf;
    logic [SLOTS-1:0]            sel_vld;
    logic [SLOTS-1:0][PTR_W-1:0] sel_ptr;
    tgt_kind_e                   kind;

    assign op        = dir_op_e'(cmd_op);
    assign cmd_ready = !busy;
    assign fire      = cmd_valid && cmd_ready;

    lpdir_entry_bank #(
        .ENTRIES (ENTRIES),
        .SLOTS   (SLOTS),
        .PTR_W   (PTR_W),
        .IDX_W   (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (fire && op != OP_ENUM),
        .upd_op    (op),
        .sel_idx   (cmd_entry),
        .upd_node  (cmd_node),
        .sel_ovf   (sel_ovf),
        .sel_vld   (sel_vld),
        .sel_ptr   (sel_ptr)
    );

    lpdir_enum #(
        .SLOTS (SLOTS),
        .PTR_W (PTR_W)
    ) u_enum (
        .clk       (clk),
        .rst       (rst),
        .start     (fire && op == OP_ENUM),
        .req       (cmd_node),
        .src_ovf   (sel_ovf),
        .src_vld   (sel_vld),
        .src_ptr   (sel_ptr),
        .busy      (busy),
        .out_valid (out_valid),
        .out_kind  (kind),
        .out_node  (out_node),
        .out_last  (out_last)
    );

    assign out_kind = kind;

endmodule

// File: tb/lpdir_sharer_dir_test.sv
`timescale 1ns/1ps
module lpdir_sharer_dir_test;
    localparam int NODES   = 64;
    localparam int SLOTS   = 5;
    localparam int ENTRIES = 8;
    localparam int PTR_W   = 6;
    localparam int IDX_W   = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = 2'b00;
    logic [IDX_W-1:0] cmd_entry = '0;
    logic [PTR_W-1:0] cmd_node = '0;
    logic             cmd_ready;
    logic             out_valid;
    logic [1:0]       out_kind;
    logic [PTR_W-1:0] out_node;
    logic             out_last;

    always #2 clk = ~clk;

    lpdir_sharer_dir #(.NODES(NODES), .SLOTS(SLOTS), .ENTRIES(ENTRIES)) uut (
        .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_entry (cmd_entry), .cmd_node (cmd_node), .cmd_ready (cmd_ready),
        .out_valid (out_valid), .out_kind (out_kind), .out_node (out_node),
        .out_last (out_last)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference: true sharer bit vector plus the slot behaviour the requirements define
    bit ref_bits [ENTRIES][NODES];
    bit ref_ovf  [ENTRIES];
    bit ref_vld  [ENTRIES][SLOTS];
    int ref_ptr  [ENTRIES][SLOTS];

    int got_node [SLOTS+2];
    int got_n;
    bit got_all, got_none, stream_ok;
    int got_all_node;

    bit [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model(input int op, input int ent, input int node);
        int slot;
        bit present;
        if (op == 0) begin
            ref_bits[ent][node] = 1;
            if (!ref_ovf[ent]) begin
                present = 0;
                slot = -1;
                for (int s = 0; s < SLOTS; s++) begin
                    if (ref_vld[ent][s] && ref_ptr[ent][s] == node) present = 1;
                    if (!ref_vld[ent][s] && slot < 0) slot = s;
                end
                if (!present) begin
                    if (slot < 0) ref_ovf[ent] = 1;
                    else begin
                        ref_vld[ent][slot] = 1;
                        ref_ptr[ent][slot] = node;
                    end
                end
            end
        end else if (op == 1) begin
            ref_bits[ent][node] = 0;
            for (int s = 0; s < SLOTS; s++)
                if (ref_vld[ent][s] && ref_ptr[ent][s] == node) ref_vld[ent][s] = 0;
        end else if (op == 2) begin
            ref_ovf[ent] = 0;
            for (int s = 0; s < SLOTS; s++) ref_vld[ent][s] = 0;
            for (int n = 0; n < NODES; n++) ref_bits[ent][n] = 0;
        end
    endtask

    task automatic issue(input int op, input int ent, input int node);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_entry = IDX_W'(ent);
        cmd_node  = PTR_W'(node);
        @(negedge clk);
        cmd_valid = 1'b0;
        model(op, ent, node);
    endtask

    task automatic enumerate(input int ent, input int req);
        int guard;
        got_n = 0; got_all = 0; got_none = 0; got_all_node = -1; stream_ok = 1;
        guard = 0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'b11;
        cmd_entry = IDX_W'(ent);
        cmd_node  = PTR_W'(req);
        @(negedge clk);
        cmd_valid = 1'b0;
        forever begin
            if (!out_valid || cmd_ready) begin
                stream_ok = 0;
                break;
            end
            if (out_kind == 2'b01) begin
                if (got_n < SLOTS + 2) got_node[got_n] = int'(out_node);
                got_n++;
            end else if (out_kind == 2'b10) begin
                got_all = 1;
                got_all_node = int'(out_node);
            end else begin
                got_none = 1;
            end
            if (out_last) break;
            guard++;
            if (guard > SLOTS + 2) begin
                stream_ok = 0;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        if (out_valid || !cmd_ready) stream_ok = 0;
    endtask

    task automatic verify(input int ent, input int req, input string tag);
        int exp_n;
        int exp_list [SLOTS];
        int uncovered;
        bit hit;
        enumerate(ent, req);
        check(stream_ok, "R9", "stream framing ok", int'(stream_ok), 1);
        if (ref_ovf[ent]) begin
            check(got_all && got_n == 0 && !got_none, tag, "single broadcast beat", got_n, 0);
            check(got_all_node == req, tag, "broadcast excluded node", got_all_node, req);
        end else begin
            exp_n = 0;
            for (int s = 0; s < SLOTS; s++)
                if (ref_vld[ent][s] && ref_ptr[ent][s] != req) begin
                    exp_list[exp_n] = ref_ptr[ent][s];
                    exp_n++;
                end
            check(!got_all, tag, "no broadcast", int'(got_all), 0);
            if (exp_n == 0) begin
                check(got_none && got_n == 0, tag, "empty beat count", got_n, 0);
            end else begin
                check(got_n == exp_n && !got_none, tag, "node beat count", got_n, exp_n);
                for (int i = 0; i < exp_n && i < got_n; i++)
                    check(got_node[i] == exp_list[i], tag, $sformatf("beat %0d node", i), got_node[i], exp_list[i]);
            end
        end
        uncovered = 0;
        for (int n = 0; n < NODES; n++) begin
            if (ref_bits[ent][n] && n != req) begin
                hit = got_all;
                for (int i = 0; i < got_n && i < SLOTS + 2; i++)
                    if (got_node[i] == n) hit = 1;
                if (!hit) uncovered++;
            end
        end
        check(uncovered == 0, "R10", "uncovered true sharers", uncovered, 0);
    endtask

    task automatic t_reset;
        check(cmd_ready == 1'b1, "R1", "cmd_ready after reset", int'(cmd_ready), 1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        for (int e = 0; e < ENTRIES; e++) verify(e, 0, "R1");
    endtask

    task automatic t_add_order;
        issue(0, 1, 5); issue(0, 1, 9); issue(0, 1, 3);
        verify(1, 60, "R2");
    endtask

    task automatic t_duplicate;
        issue(0, 1, 9);
        verify(1, 60, "R3");
    endtask

    task automatic t_requester;
        verify(1, 9, "R8");
        issue(0, 3, 2);
        verify(3, 2, "R8");
    endtask

    task automatic t_remove;
        issue(1, 1, 9); issue(1, 1, 40);
        verify(1, 60, "R6");
        issue(0, 1, 11);
        verify(1, 60, "R6");
    endtask

    task automatic t_overflow;
        for (int n = 1; n <= SLOTS; n++) issue(0, 2, n);
        verify(2, 60, "R4");
        issue(0, 2, 3);
        verify(2, 60, "R3");
        issue(0, 2, 6);
        verify(2, 60, "R4");
        verify(2, 2, "R4");
    endtask

    task automatic t_sticky;
        issue(1, 2, 1); issue(1, 2, 6);
        verify(2, 33, "R5");
        issue(0, 2, 7);
        verify(2, 33, "R5");
    endtask

    task automatic t_clear;
        issue(2, 2, 0);
        verify(2, 0, "R7");
        issue(0, 2, 8);
        verify(2, 0, "R7");
        verify(1, 60, "R10");
    endtask

    task automatic t_sweep;
        int ent, node, sel;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ent  = int'(lfsr[2:0]);
            node = int'(lfsr[6:3]);
            sel  = int'(lfsr[11:8]);
            if (sel < 8)       issue(0, ent, node);
            else if (sel < 13) issue(1, ent, node);
            else if (sel == 13) issue(2, ent, node);
            else               verify(ent, int'(lfsr[15:12]), "R10");
        end
        for (int e = 0; e < ENTRIES; e++) verify(e, 63, "R10");
    endtask

    initial begin
        for (int e = 0; e < ENTRIES; e++) model(2, e, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_add_order();
        t_duplicate();
        t_requester();
        t_remove();
        t_overflow();
        t_sticky();
        t_clear();
        t_sweep();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule